// File: doc/BRIEF.md
# Two-Channel Peripheral Data Flow Controller

This block moves bytes from one peripheral to another over a shared data side. It has two independent channels. The CPU arms a channel by writing a five-byte descriptor, one byte at a time, to that channel's descriptor address. The channel starts on its own as soon as the fifth byte lands; there is no separate start command. The descriptor selects the source peripheral, the destination peripheral, the byte count and one option bit.

The data side has one handshake pair per peripheral. A byte moves in the cycle where the source shows valid data and the destination is ready. The routing from source to destination is combinational. A small register port gives access to the global enable, the channel status and a running CRC-16 of the bytes that channel 0 moves.

Top module: `dflow_ctrl`

## Requirements
- R1: After reset, every register reads as follows: control at address 0 reads 0x00, status at address 1 reads 0x00, CRC low at address 4 reads 0xFF and CRC high at address 5 reads 0xFF. No src_ready_o or dst_valid_o bit is high.
- R2: Descriptor bytes for channel 0 go to address 2 and bytes for channel 1 go to address 3. They are written in this order: source select (low 2 bits used), destination select (low 2 bits used), length low byte, length high byte, options (bit 0 used). The channel shows busy (status bit 0 for channel 0, bit 1 for channel 1) right after the fifth byte is written, and not before.
- R3: A busy channel moves one byte per clock, and only while src_valid_i of its source and dst_ready_i of its destination are both high. In that cycle it raises src_ready_o of the source and dst_valid_o of the destination, and it drives the source byte onto the destination's dst_data_o lane.
- R4: A channel moves exactly the programmed number of bytes. After the last byte it clears busy and sets a sticky done flag (status bit 2 for channel 0, bit 3 for channel 1). A length of zero sets done at arming and moves nothing.
- R5: A descriptor write to a busy channel is ignored and sets a sticky error flag (status bit 4 for channel 0, bit 5 for channel 1). Writing a 1 to a done or error bit at address 1 clears that bit.
- R6: Control bit 0 is the global enable. While it is clear, no byte moves, no descriptor byte is taken and no status bit changes. A stalled transfer resumes where it left off when the bit is set again.
- R7: While channel 0 is busy and shares its source or its destination select with channel 1, channel 1 moves nothing.
- R8: The CRC is CRC-16 with polynomial 0x1021, shifted MSB first, seed 0xFFFF. It is updated with each byte that channel 0 moves and is reset to the seed when channel 0 is armed. When options bit 0 of channel 0 is set, the CRC is not updated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| src_valid_i | input | 4 | Per-peripheral source has a byte |
| src_data_i | input | 32 | Per-peripheral source byte, one 8-bit lane each |
| src_ready_o | output | 4 | Per-peripheral source byte taken this cycle |
| dst_valid_o | output | 4 | Per-peripheral destination byte offered this cycle |
| dst_data_o | output | 32 | Per-peripheral destination byte, one 8-bit lane each |
| dst_ready_i | input | 4 | Per-peripheral destination can accept |

## Verification
The handshake outputs and the routed data are combinational, so they are due in the same cycle as the handshake inputs. The bench drives the handshake inputs on the falling edge and compares the outputs one nanosecond later. The effect of a moved byte on status, the count and the CRC appears one edge later. Register reads are combinational, so the bench reads them in the cycle after the write or move it is checking, at a point where the handshakes are held low. A bench model tracks the descriptor pointer, the counts, the flags and the CRC, and it updates them on the same edges the design does.

// File: rtl/dflow_pkg.sv
package dflow_pkg;
  localparam int NCH        = 2;
  localparam int DESC_BYTES = 5;
  localparam int LEN_W      = 16;
  localparam logic [15:0] CRC_POLY = 16'h1021;
  localparam logic [15:0] CRC_SEED = 16'hFFFF;

  localparam logic [2:0] A_CTRL   = 3'd0;
  localparam logic [2:0] A_STAT   = 3'd1;
  localparam logic [2:0] A_DESC0  = 3'd2;
  localparam logic [2:0] A_CRC_LO = 3'd4;
  localparam logic [2:0] A_CRC_HI = 3'd5;

  function automatic logic [15:0] crc16_byte(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c ^ {b, 8'h00};
    for (int i = 0; i < 8; i++) r = r[15] ? ((r << 1) ^ CRC_POLY) : (r << 1);
    return r;
  endfunction
endpackage

// File: rtl/dflow_chan.sv
module dflow_chan
  import dflow_pkg::*;
#(
  parameter int SEL_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             desc_we_i,
  input  logic [7:0]       desc_byte_i,
  input  logic             move_i,
  input  logic             clr_done_i,
  input  logic             clr_err_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o,
  output logic             arm_o,
  output logic             opt_o,
  output logic [SEL_W-1:0] src_o,
  output logic [SEL_W-1:0] dst_o
);
  localparam logic [2:0] PTR_LAST = 3'(DESC_BYTES - 1);

  logic [2:0]       ptr_q;
  logic [LEN_W-1:0] len_q;
  logic [LEN_W-1:0] cnt_q;

  assign arm_o = en_i && desc_we_i && !busy_o && (ptr_q == PTR_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= '0;
      len_q  <= '0;
      cnt_q  <= '0;
      busy_o <= 1'b0;
      done_o <= 1'b0;
      err_o  <= 1'b0;
      opt_o  <= 1'b0;
      src_o  <= '0;
      dst_o  <= '0;
    end else if (en_i) begin
      if (clr_done_i) done_o <= 1'b0;
      if (clr_err_i)  err_o  <= 1'b0;
      if (desc_we_i) begin
        if (busy_o) begin
          err_o <= 1'b1;
        end else begin
          case (ptr_q)
            3'd0:    src_o        <= desc_byte_i[SEL_W-1:0];
            3'd1:    dst_o        <= desc_byte_i[SEL_W-1:0];
            3'd2:    len_q[7:0]   <= desc_byte_i;
            3'd3:    len_q[15:8]  <= desc_byte_i;
            default: opt_o        <= desc_byte_i[0];
          endcase
          ptr_q <= (ptr_q == PTR_LAST) ? 3'd0 : ptr_q + 3'd1;
        end
      end
      if (arm_o) begin
        cnt_q  <= len_q;
        busy_o <= (len_q != '0);
        if (len_q == '0) done_o <= 1'b1;
      end
      if (move_i) begin
        cnt_q <= cnt_q - LEN_W'(1);
        if (cnt_q == LEN_W'(1)) begin
          busy_o <= 1'b0;
          done_o <= 1'b1;
        end
      end
    end
  end

  AST_ARM_SETS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm_o && len_q != '0) |=> busy_o); // R2
  AST_MOVE_NEEDS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    move_i |-> (busy_o && en_i)); // R3
  AST_LAST_BYTE_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (move_i && cnt_q == LEN_W'(1)) |=> (!busy_o && done_o)); // R4
  AST_BUSY_WRITE_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && desc_we_i && busy_o) |=> err_o); // R5
  AST_FROZEN_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> ($stable(cnt_q) && $stable(busy_o) && $stable(ptr_q) && $stable(done_o))); // R6
endmodule

// File: rtl/dflow_crc16.sv
module dflow_crc16
  import dflow_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        seed_i,
  input  logic        upd_i,
  input  logic [7:0]  byte_i,
  output logic [15:0] crc_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_o <= CRC_SEED;
    else if (seed_i) crc_o <= CRC_SEED;
    else if (upd_i)  crc_o <= crc16_byte(crc_o, byte_i);
  end

  AST_CRC_SEED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seed_i |=> (crc_o == CRC_SEED)); // R8
  AST_CRC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!seed_i && !upd_i) |=> $stable(crc_o)); // R8
endmodule

// File: rtl/dflow_ctrl.sv
module dflow_ctrl
  import dflow_pkg::*;
#(
  parameter int N_PERIPH = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  reg_we_i,
  input  logic [2:0]            reg_addr_i,
  input  logic [7:0]            reg_wdata_i,
  output logic [7:0]            reg_rdata_o,
  input  logic [N_PERIPH-1:0]   src_valid_i,
  input  logic [N_PERIPH*8-1:0] src_data_i,
  output logic [N_PERIPH-1:0]   src_ready_o,
  output logic [N_PERIPH-1:0]   dst_valid_o,
  output logic [N_PERIPH*8-1:0] dst_data_o,
  input  logic [N_PERIPH-1:0]   dst_ready_i
);
  localparam int SEL_W = (N_PERIPH > 1) ? $clog2(N_PERIPH) : 1;

  logic             en_q;
  logic [NCH-1:0]   busy, done, err, arm, mv, opt, dwe, cdone, cerr;
  logic [SEL_W-1:0] src_s [NCH];
  logic [SEL_W-1:0] dst_s [NCH];
  logic             share;
  logic [15:0]      crc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b0;
    else if (reg_we_i && reg_addr_i == A_CTRL) en_q <= reg_wdata_i[0];
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign dwe[c]   = reg_we_i && (reg_addr_i == A_DESC0 + 3'(c));
    assign cdone[c] = reg_we_i && (reg_addr_i == A_STAT) && reg_wdata_i[2+c];
    assign cerr[c]  = reg_we_i && (reg_addr_i == A_STAT) && reg_wdata_i[4+c];

    dflow_chan #(.SEL_W(SEL_W)) u_chan (
      .clk_i, .rst_ni,
      .en_i       (en_q),
      .desc_we_i  (dwe[c]),
      .desc_byte_i(reg_wdata_i),
      .move_i     (mv[c]),
      .clr_done_i (cdone[c]),
      .clr_err_i  (cerr[c]),
      .busy_o     (busy[c]),
      .done_o     (done[c]),
      .err_o      (err[c]),
      .arm_o      (arm[c]),
      .opt_o      (opt[c]),
      .src_o      (src_s[c]),
      .dst_o      (dst_s[c])
    );
  end

  // fixed priority: channel 0 owns any peripheral it shares while busy
  assign share = busy[0] && ((src_s[1] == src_s[0]) || (dst_s[1] == dst_s[0]));
  assign mv[0] = en_q && busy[0] && src_valid_i[src_s[0]] && dst_ready_i[dst_s[0]];
  assign mv[1] = en_q && busy[1] && !share && src_valid_i[src_s[1]] && dst_ready_i[dst_s[1]];

  always_comb begin
    src_ready_o = '0;
    dst_valid_o = '0;
    dst_data_o  = '0;
    for (int c = 0; c < NCH; c++) begin
      if (mv[c]) begin
        src_ready_o[src_s[c]] = 1'b1;
        dst_valid_o[dst_s[c]] = 1'b1;
        dst_data_o[dst_s[c]*8 +: 8] = src_data_i[src_s[c]*8 +: 8];
      end
    end
  end

  dflow_crc16 u_crc (
    .clk_i, .rst_ni,
    .seed_i(arm[0]),
    .upd_i (mv[0] && !opt[0]),
    .byte_i(src_data_i[src_s[0]*8 +: 8]),
    .crc_o (crc)
  );

  always_comb begin
    case (reg_addr_i)
      A_CTRL:   reg_rdata_o = {7'd0, en_q};
      A_STAT:   reg_rdata_o = {2'b00, err, done, busy};
      A_CRC_LO: reg_rdata_o = crc[7:0];
      A_CRC_HI: reg_rdata_o = crc[15:8];
      default:  reg_rdata_o = 8'h00;
    endcase
  end

  AST_CH0_PRIORITY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy[0] && busy[1] && (src_s[0] == src_s[1] || dst_s[0] == dst_s[1])) |-> !src_ready_o[src_s[1]] || mv[0]); // R7
  AST_PUSH_NEEDS_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dst_valid_o & ~dst_ready_i) == '0); // R3
  AST_POP_NEEDS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_ready_o & ~src_valid_i) == '0); // R3
  AST_OFF_NO_MOVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |-> (dst_valid_o == '0)); // R6
endmodule

// File: tb/tb_dflow_ctrl.sv
`timescale 1ns/1ps
module tb_dflow_ctrl;
  localparam int NP = 4;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          reg_we_i = 1'b0;
  logic [2:0]    reg_addr_i = '0;
  logic [7:0]    reg_wdata_i = '0;
  logic [7:0]    reg_rdata_o;
  logic [NP-1:0] src_valid_i = '0;
  logic [NP*8-1:0] src_data_i = '0;
  logic [NP-1:0] src_ready_o;
  logic [NP-1:0] dst_valid_o;
  logic [NP*8-1:0] dst_data_o;
  logic [NP-1:0] dst_ready_i = '0;

  always #2 clk_i = ~clk_i;

  dflow_ctrl #(.N_PERIPH(NP)) dut (.*);

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // reference model
  bit        en_m;
  bit [1:0]  busy_m, done_m, err_m, opt_m;
  bit [1:0]  s_m [2];
  bit [1:0]  d_m [2];
  int        rem_m [2];
  int        ptr_m [2];
  bit [7:0]  dbuf [2][5];
  bit [15:0] crc_m;
  bit [7:0]  pdat [NP];

  function automatic bit [15:0] ref_crc(input bit [15:0] c, input bit [7:0] b);
    bit [15:0] r = c;
    for (int k = 7; k >= 0; k--) begin
      bit fb = r[15] ^ b[k];
      r = {r[14:0], 1'b0};
      if (fb) r = r ^ 16'h1021;
    end
    return r;
  endfunction

  function automatic bit [7:0] stat_m();
    return {2'b00, err_m, done_m, busy_m};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk_i);
    src_valid_i = '0; dst_ready_i = '0;
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
    if (a == 3'd0) en_m = d[0];
    if (a == 3'd1 && en_m) begin
      done_m = done_m & ~d[3:2];
      err_m  = err_m & ~d[5:4];
    end
  endtask

  task automatic rd(input string req, input logic [2:0] a, input logic [7:0] exp);
    @(negedge clk_i);
    src_valid_i = '0; dst_ready_i = '0;
    reg_addr_i = a;
    #1 chk(req, reg_rdata_o, exp);
  endtask

  task automatic desc_byte(input int ch, input bit [7:0] b);
    wr(3'(2 + ch), b);
    if (!en_m) return;
    if (busy_m[ch]) begin err_m[ch] = 1; return; end
    dbuf[ch][ptr_m[ch]] = b;
    if (ptr_m[ch] == 4) begin
      int len = {dbuf[ch][3], dbuf[ch][2]};
      s_m[ch] = dbuf[ch][0][1:0];
      d_m[ch] = dbuf[ch][1][1:0];
      opt_m[ch] = b[0];
      rem_m[ch] = len;
      if (len == 0) done_m[ch] = 1; else busy_m[ch] = 1;
      if (ch == 0) crc_m = 16'hFFFF;
      ptr_m[ch] = 0;
    end else ptr_m[ch]++;
  endtask

  task automatic desc(input int ch, input bit [7:0] s, input bit [7:0] d,
                      input bit [15:0] len, input bit [7:0] o);
    desc_byte(ch, s); desc_byte(ch, d);
    desc_byte(ch, len[7:0]); desc_byte(ch, len[15:8]); desc_byte(ch, o);
  endtask

  // one data cycle; outputs compared combinationally, model advanced for the next edge
  task automatic step(input string req, input logic [NP-1:0] sv, input logic [NP-1:0] dr);
    bit m0, m1, blk;
    logic [NP-1:0] esr, edv;
    logic [NP*8-1:0] edd;
    @(negedge clk_i);
    src_valid_i = sv; dst_ready_i = dr;
    for (int p = 0; p < NP; p++) src_data_i[p*8 +: 8] = pdat[p];
    #1;
    blk = busy_m[0] && (s_m[1] == s_m[0] || d_m[1] == d_m[0]);
    m0 = en_m && busy_m[0] && sv[s_m[0]] && dr[d_m[0]];
    m1 = en_m && busy_m[1] && !blk && sv[s_m[1]] && dr[d_m[1]];
    esr = '0; edv = '0; edd = '0;
    if (m0) begin esr[s_m[0]] = 1; edv[d_m[0]] = 1; edd[d_m[0]*8 +: 8] = pdat[s_m[0]]; end
    if (m1) begin esr[s_m[1]] = 1; edv[d_m[1]] = 1; edd[d_m[1]*8 +: 8] = pdat[s_m[1]]; end
    chk(req, {src_ready_o, dst_valid_o, dst_data_o}, {esr, edv, edd});
    if (m0) begin
      if (!opt_m[0]) crc_m = ref_crc(crc_m, pdat[s_m[0]]);
      pdat[s_m[0]]++;
      if (--rem_m[0] == 0) begin busy_m[0] = 0; done_m[0] = 1; end
    end
    if (m1) begin
      pdat[s_m[1]]++;
      if (--rem_m[1] == 0) begin busy_m[1] = 0; done_m[1] = 1; end
    end
  endtask

  task automatic run_random(input string req, input int limit);
    for (int i = 0; i < limit && busy_m != 0; i++) step(req, 4'($urandom), 4'($urandom));
  endtask

  task automatic summary();
    if (finished) return;
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=complete");
    summary();
  end

  initial begin
    void'($urandom(32'd1234));
    for (int p = 0; p < NP; p++) pdat[p] = 8'(p * 16);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state
    #1 chk("R1 handshake idle", {src_ready_o, dst_valid_o}, 0);
    rd("R1 ctrl", 3'd0, 8'h00);
    rd("R1 status", 3'd1, 8'h00);
    rd("R1 crc lo", 3'd4, 8'hFF);
    rd("R1 crc hi", 3'd5, 8'hFF);

    // R6 descriptor writes ignored while disabled
    desc(0, 8'd3, 8'd3, 16'd1, 8'd0);
    rd("R6 disabled desc ignored", 3'd1, 8'h00);

    wr(3'd0, 8'h01);
    rd("R6 enable reads back", 3'd0, 8'h01);

    // R2 arming only on fifth byte; CRC check string "123456789"
    desc_byte(0, 8'd1); desc_byte(0, 8'd2); desc_byte(0, 8'd9); desc_byte(0, 8'd0);
    rd("R2 not busy after 4 bytes", 3'd1, 8'h00);
    desc_byte(0, 8'd0);
    rd("R2 busy after 5th byte", 3'd1, 8'h01);
    pdat[1] = 8'h31;
    run_random("R3 random handshake ch0", 1000);
    rd("R4 done after length", 3'd1, 8'h04);
    rd("R8 crc lo check value", 3'd4, 8'hB1);
    rd("R8 crc hi check value", 3'd5, 8'h29);
    wr(3'd1, 8'h04);
    rd("R5 done cleared by W1C", 3'd1, 8'h00);

    // R8 seed on arm, R5 busy write error
    desc(0, 8'd0, 8'd3, 16'd3, 8'd0);
    rd("R8 crc seeded on arm", 3'd4, 8'hFF);
    desc_byte(0, 8'h55);
    rd("R5 error on busy write", 3'd1, 8'h11);
    wr(3'd1, 8'h10);
    rd("R5 error cleared", 3'd1, 8'h01);

    // R6 stall while disabled, then resume
    wr(3'd0, 8'h00);
    repeat (3) step("R6 no move while disabled", 4'hF, 4'hF);
    wr(3'd0, 8'h01);
    rd("R6 still busy after stall", 3'd1, 8'h01);
    repeat (3) step("R6 resume after enable", 4'hF, 4'hF);
    rd("R4 done after resume", 3'd1, 8'h04);
    wr(3'd1, 8'h04);

    // R4 zero length
    desc(1, 8'd0, 8'd1, 16'd0, 8'd0);
    rd("R4 zero length done at arm", 3'd1, 8'h08);
    step("R4 zero length moves nothing", 4'hF, 4'hF);
    wr(3'd1, 8'h08);

    // R7 shared source: channel 0 first
    desc(0, 8'd2, 8'd0, 16'd4, 8'd0);
    desc(1, 8'd2, 8'd1, 16'd2, 8'd0);
    repeat (7) step("R7 channel 0 priority", 4'hF, 4'hF);
    rd("R7 both done", 3'd1, 8'h0C);
    wr(3'd1, 8'h0C);

    // R8 bypass option
    desc(0, 8'd1, 8'd2, 16'd2, 8'd1);
    run_random("R8 bypass moves", 500);
    rd("R8 crc untouched when bypassed lo", 3'd4, 8'hFF);
    rd("R8 crc untouched when bypassed hi", 3'd5, 8'hFF);
    wr(3'd1, 8'h0C);

    // constrained random transfers on both channels
    for (int t = 0; t < 40; t++) begin
      desc(0, 8'($urandom), 8'($urandom), 16'($urandom_range(1, 20)), 8'($urandom_range(0, 1)));
      desc(1, 8'($urandom), 8'($urandom), 16'($urandom_range(0, 20)), 8'h00);
      run_random("R3 random two-channel traffic", 3000);
      rd("R4 random status", 3'd1, stat_m());
      rd("R8 random crc lo", 3'd4, crc_m[7:0]);
      rd("R8 random crc hi", 3'd5, crc_m[15:8]);
      wr(3'd1, 8'h3C);
    end

    summary();
  end
endmodule